// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor interrupt controller. It divides the core clock by a power of two and counts that slower tick through a period that software programs. Software writes a starting count, a divide setting and a timer entry holding a mask bit, a mode bit and an 8-bit vector. At each expiry the block raises a one-clock request that carries the vector. A current-count register shows how far the countdown has got.

One-shot mode expires once, then stays idle until software writes a new starting count. Periodic mode expires again and again, each time after the same number of ticks. Masking silences the request but lets the count go on. Writing a starting count of zero stops the timer. Prioritising the request and delivering it to the core are handled elsewhere.

Top module: `lt_timer`

## Requirements
- R1: After reset the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), the starting count, divide setting and current count read 0, and `irq_pulse` is low.
- R2: Register addresses are 0 for the starting count (32 bits), 1 for the divide setting (bits 2:0), 2 for the timer entry (vector in bits 7:0, mask at bit 16, periodic at bit 17) and 3 for the current count. A write to address 3 is ignored.
- R3: A divide setting of d makes one count tick last 2^d clocks, for d from 0 to 7.
- R4: In one-shot mode (bit 17 = 0), with starting count N > 0 written on clock edge W, the request pulses once, high in the cycle after edge W + (N+1)·2^d. Afterwards the current count reads 0, and the timer never pulses again, even after a switch to periodic mode.
- R5: In periodic mode (bit 17 = 1) with N > 0, the request pulses after edges W + k·(N+1)·2^d for k = 1, 2, 3, and so on.
- R6: Writing a starting count of 0 stops the timer in either mode: no pulse follows and the current count reads 0.
- R7: While the mask bit is set no pulse is produced, but the count keeps running. Clearing the mask lets the next scheduled expiry through, at its original time.
- R8: `irq_pulse` is high for exactly one clock per expiry, and `irq_vector` then equals the vector in the timer entry (0 otherwise).
- R9: Writing a new starting count while the timer runs restarts the countdown from that write.
- R10: While running, the current count reads N minus the ticks elapsed in the present period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_pulse | output | 1 | One-clock expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A wrong elapsed-tick count or prescaler phase moves the expiry. The bench sees this in the first period as a pulse that arrives early or late against a cycle-exact schedule, and in the current-count readback taken inside that period. A one-shot run flag that stays set, or a mask that blocks the counter, shows up as an extra pulse or a missing one. The watch windows after the last expected pulse and the unmask test catch these within one period.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int CNT_W   = 32;
    localparam int VEC_W   = 8;
    localparam int SHIFT_W = 3;
    localparam int PRESC_W = (1 << SHIFT_W) - 1;
    localparam int ADDR_W  = 2;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;

    typedef enum logic [ADDR_W-1:0] {
        REG_START = 2'd0,
        REG_DIV   = 2'd1,
        REG_ENTRY = 2'd2,
        REG_CUR   = 2'd3
    } lt_addr_e;

    typedef struct packed {
        logic             mask;
        logic             periodic;
        logic [VEC_W-1:0] vector;
    } lt_entry_t;

    localparam lt_entry_t ENTRY_RESET = '{mask: 1'b1, periodic: 1'b0, vector: '0};

    function automatic logic [PRESC_W-1:0] shift_mask(input logic [SHIFT_W-1:0] s);
        logic [PRESC_W-1:0] ones;
        ones = '1;
        return ~(ones << s);
    endfunction

    function automatic lt_entry_t entry_from_word(input logic [CNT_W-1:0] w);
        lt_entry_t e;
        e.mask     = w[MASK_BIT];
        e.periodic = w[PER_BIT];
        e.vector   = w[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [CNT_W-1:0] entry_to_word(input lt_entry_t e);
        logic [CNT_W-1:0] w;
        w = '0;
        w[MASK_BIT]    = e.mask;
        w[PER_BIT]     = e.periodic;
        w[VEC_W-1:0]   = e.vector;
        return w;
    endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
    import lt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [PRESC_W-1:0] phase_q;
    logic [PRESC_W-1:0] sel_mask;

    assign sel_mask = shift_mask(shift);
    assign tick     = ((phase_q & sel_mask) == sel_mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // With a divide above one, two ticks in a row can only come from a change to divide-by-one.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && shift != '0 && !restart) |=> (!tick || shift == '0));

endmodule

// File: rtl/lt_counter.sv
module lt_counter
    import lt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_nonzero,
    input  logic             tick,
    input  logic             periodic,
    input  logic [CNT_W-1:0] start_cnt,
    output logic             expire,
    output logic [CNT_W-1:0] cur_count
);

    logic [CNT_W-1:0] elapsed_q;
    logic             running_q;

    assign expire    = running_q && tick && !load && (elapsed_q == start_cnt);
    assign cur_count = running_q ? (start_cnt - elapsed_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
            running_q <= 1'b0;
        end else if (load) begin
            elapsed_q <= '0;
            running_q <= load_nonzero;
        end else if (running_q && tick) begin
            if (elapsed_q == start_cnt) begin
                elapsed_q <= '0;
                running_q <= periodic;
            end else begin
                elapsed_q <= elapsed_q + 1'b1;
            end
        end
    end

    assert_elapsed_bound_R10: assert property (@(posedge clk) disable iff (rst)
        running_q |-> (elapsed_q <= start_cnt));

    assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (rst)
        (expire && !periodic) |=> !running_q);

    assert_zero_start_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (start_cnt == '0) |-> !expire);

endmodule

// File: rtl/lt_regs.sv
module lt_regs
    import lt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [CNT_W-1:0]   cur_count,
    output logic [CNT_W-1:0]   start_cnt,
    output logic [SHIFT_W-1:0] shift,
    output lt_entry_t          entry,
    output logic               load,
    output logic [CNT_W-1:0]   rd_data
);

    lt_addr_e wsel;
    lt_addr_e rsel;

    assign wsel = lt_addr_e'(wr_addr);
    assign rsel = lt_addr_e'(rd_addr);
    assign load = wr_en && (wsel == REG_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_cnt <= '0;
            shift     <= '0;
            entry     <= ENTRY_RESET;
        end else if (wr_en) begin
            case (wsel)
                REG_START: start_cnt <= wr_data;
                REG_DIV:   shift     <= wr_data[SHIFT_W-1:0];
                REG_ENTRY: entry     <= entry_from_word(wr_data);
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rsel)
            REG_START: rd_data = start_cnt;
            REG_DIV:   rd_data = {{(CNT_W-SHIFT_W){1'b0}}, shift};
            REG_ENTRY: rd_data = entry_to_word(entry);
            default:   rd_data = cur_count;
        endcase
    end

    assert_reset_masked_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (entry.mask && start_cnt == '0 && shift == '0));

endmodule

// File: rtl/lt_timer.sv
module lt_timer
    import lt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_pulse,
    output logic [VEC_W-1:0]  irq_vector
);

    logic [CNT_W-1:0]   start_cnt;
    logic [SHIFT_W-1:0] shift;
    lt_entry_t          entry;
    logic               load;
    logic               tick;
    logic               expire;
    logic [CNT_W-1:0]   cur_count;

    lt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .cur_count (cur_count),
        .start_cnt (start_cnt),
        .shift     (shift),
        .entry     (entry),
        .load      (load),
        .rd_data   (rd_data)
    );

    lt_prescaler u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (load),
        .shift   (shift),
        .tick    (tick)
    );

    lt_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .load         (load),
        .load_nonzero (wr_data != '0),
        .tick         (tick),
        .periodic     (entry.periodic),
        .start_cnt    (start_cnt),
        .expire       (expire),
        .cur_count    (cur_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end else if (expire && !entry.mask) begin
            irq_pulse  <= 1'b1;
            irq_vector <= entry.vector;
        end else begin
            irq_pulse  <= 1'b0;
            irq_vector <= '0;
        end
    end

    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);

    assert_pulse_vector_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (irq_vector == $past(entry.vector)));

    assert_masked_silent_R7: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> !$past(entry.mask));

endmodule

// File: tb/lt_timer_tb.sv
module lt_timer_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         at;
        logic [7:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lt_timer u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .irq_pulse  (irq_pulse),
        .irq_vector (irq_vector)
    );

    // Monitor: every pulse must match the oldest expected item.
    always @(negedge clk) begin
        if (!rst && irq_pulse) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected pulse at cycle %0d vector %0h, expected none", cyc, irq_vector);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at != cyc || e.vec != irq_vector) begin
                    errors++;
                    $display("FAIL %s pulse at cycle %0d vec %0h, expected cycle %0d vec %0h",
                             e.tag, cyc, irq_vector, e.at, e.vec);
                end
            end
        end
    end

    task automatic push(input int at, input logic [7:0] vec, input string tag);
        exp_t e;
        e.at = at; e.vec = vec; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int edge_cyc);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        edge_cyc = cyc;
        wr_en = 1'b0;
    endtask

    task automatic check_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d got %0h expected %0h", tag, a, rd_data, exp);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drained(input string tag);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing %0d pulses, expected 0 outstanding", tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    localparam logic [31:0] MASK = 32'h0001_0000;
    localparam logic [31:0] PER  = 32'h0002_0000;

    initial begin
        int w;
        int w2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        checks++;
        if (irq_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1 irq_pulse %0b expected 0", irq_pulse);
        end
        check_rd(2'd0, 32'h0, "R1");
        check_rd(2'd1, 32'h0, "R1");
        check_rd(2'd2, MASK, "R1");
        check_rd(2'd3, 32'h0, "R1");

        // R2 write to the current-count address ignored
        wr(2'd3, 32'h77, w);
        check_rd(2'd3, 32'h0, "R2");
        check_rd(2'd0, 32'h0, "R2");
        wr(2'd2, PER | 32'h5A, w);
        check_rd(2'd2, PER | 32'h5A, "R2");

        // R4 one-shot, divide 1, start 5
        wr(2'd2, 32'h42, w);
        wr(2'd0, 32'd5, w);
        push(w + 6, 8'h42, "R4");
        wait_until(w + 2);
        check_rd(2'd3, 32'd3, "R10");
        wait_until(w + 12);
        drained("R4");
        check_rd(2'd3, 32'd0, "R4");
        wr(2'd2, PER | 32'h42, w2);
        wait_until(w2 + 30);
        drained("R4");
        check_rd(2'd3, 32'd0, "R4");

        // R3 divide by 4, one-shot start 3
        wr(2'd2, 32'h11, w);
        wr(2'd1, 32'd2, w);
        check_rd(2'd1, 32'd2, "R2");
        wr(2'd0, 32'd3, w);
        push(w + 16, 8'h11, "R3");
        wait_until(w + 24);
        drained("R3");
        wr(2'd1, 32'd0, w);

        // R5 periodic start 4, then R6 stop by writing zero
        wr(2'd2, PER | 32'h55, w);
        wr(2'd0, 32'd4, w);
        push(w + 5, 8'h55, "R5");
        push(w + 10, 8'h55, "R5");
        push(w + 15, 8'h55, "R5");
        wait_until(w + 17);
        drained("R5");
        wr(2'd0, 32'd0, w2);
        wait_until(w2 + 30);
        drained("R6");
        check_rd(2'd3, 32'd0, "R6");

        // R9 restart mid-count
        wr(2'd0, 32'd9, w);
        wait_until(w + 4);
        wr(2'd0, 32'd2, w2);
        push(w2 + 3, 8'h55, "R9");
        push(w2 + 6, 8'h55, "R9");
        wait_until(w2 + 7);
        drained("R9");
        wr(2'd0, 32'd0, w);
        wait_until(w + 20);
        drained("R6");

        // R7 masked periodic, divide 2, start 3 (period 8 clocks)
        wr(2'd2, MASK | PER | 32'h33, w);
        wr(2'd1, 32'd1, w);
        wr(2'd0, 32'd3, w);
        wait_until(w + 4);
        check_rd(2'd3, 32'd1, "R7");
        wait_until(w + 17);
        drained("R7");
        wr(2'd2, PER | 32'h33, w2);
        push(w + 24, 8'h33, "R7");
        push(w + 32, 8'h33, "R7");
        wait_until(w + 33);
        drained("R7");
        wr(2'd0, 32'd0, w);
        wr(2'd1, 32'd0, w);

        // R6 periodic with zero start never fires
        wr(2'd0, 32'd0, w);
        wait_until(w + 40);
        drained("R6");
        check_rd(2'd3, 32'd0, "R6");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule